// File: doc/BRIEF.md
# Deadtime Calibration Pulse Timer

This block holds the gate deadtime of a bridge driver, expressed in time-base clock cycles, and sets it from the width of a chip-select pulse rather than from a written value. An SPI slave outside the block hands over each decoded command byte with a one-cycle valid strobe. A calibrate command arms the block. The next low pulse on chip-select is then counted in time-base cycles, and one sixteenth of that count, truncated, becomes the new deadtime. A zero command clears the deadtime at once and expects no pulse.

While the calibration pulse is being measured the block asserts an ignore signal, and any command byte that arrives is discarded. If serial data or serial clock toggles during the pulse, a sticky framing-error flag is raised, but the pulse still sets the deadtime. The flag stays set until a clear strobe. All inputs are assumed already synchronised to the time-base clock.

Top module: `dt_cal_timer`

## Requirements
- R1: While and right after reset, `deadtime` is 255, `frame_err` is 0 and `spi_ignore` is 0.
- R2: A strobed command byte whose bits [7:5] are 100 and whose bit 0 is 1 arms calibration; bits [4:1] have no effect. A byte with any other value in bits [7:5] changes neither the deadtime nor the arming.
- R3: A strobed command byte with bits [7:5] equal to 100 and bit 0 equal to 0, accepted while no pulse is being measured, makes `deadtime` 0 in the cycle after the strobe and cancels any pending arming.
- R4: Once armed, measurement starts on the first high-to-low transition of `cs_n` seen after arming; a `cs_n` that is already low when arming occurs must first return high. The count N is the number of clock edges at which `cs_n` is sampled low during that pulse.
- R5: In the cycle after `cs_n` is first sampled high again, `deadtime` equals floor(N/16), limited to 255 (e.g. N=480 gives 30, N=4079 gives 254, N=4080 gives 255).
- R6: The pulse counter saturates at its maximum (65535 with default parameters) instead of wrapping, so pulses longer than that still store 255.
- R7: `spi_ignore` is 1 from the cycle after the falling edge of `cs_n` is sampled until `cs_n` is sampled high; command bytes strobed in that window, including a zero command, have no effect.
- R8: Arming is consumed by one pulse; later `cs_n` pulses without a new calibrate command leave `deadtime` unchanged.
- R9: A change of `sdi` or `sck` between two consecutive clock edges while `spi_ignore` is 1 sets `frame_err`; the same pulse still updates `deadtime`.
- R10: `frame_err` stays 1 until `err_clr` is strobed (a new error in the same cycle wins); toggles of `sdi` or `sck` while `spi_ignore` is 0 never set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Synchronised chip-select, active low |
| sdi | input | 1 | Synchronised serial data in |
| sck | input | 1 | Synchronised serial clock |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command byte |
| cmd_byte | input | 8 | Decoded command byte |
| err_clr | input | 1 | Clears the framing-error flag |
| deadtime | output | 8 | Deadtime in time-base cycles |
| frame_err | output | 1 | Sticky framing-error flag |
| spi_ignore | output | 1 | High while a calibration pulse is measured |

## Verification
The assertions watch, on every cycle, that the deadtime moves only on a zero command or at the end of a measured pulse, that commands during the ignore window leave it untouched, that the zero command takes effect one cycle later, and that the framing flag rises only inside the window and holds until cleared. The exact stored quotient, the truncation and saturation corner cases, the falling-edge requirement for a late arm, and the single use of an arming can only be shown by the bench's pulse sweeps, whose expected values are computed arithmetically from the pulse lengths.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

    typedef enum logic [1:0] {
        DT_IDLE,
        DT_ARMED,
        DT_MEASURE
    } dt_state_e;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_CAL,
        CMD_ZERO
    } dt_cmd_e;

    localparam logic [2:0] DT_OPCODE = 3'b100;

    function automatic dt_cmd_e decode_cmd(input logic [7:0] b);
        if (b[7:5] != DT_OPCODE) begin
            return CMD_NONE;
        end
        return b[0] ? CMD_CAL : CMD_ZERO;
    endfunction

endpackage

// File: rtl/dtc_cmd_decode.sv
module dtc_cmd_decode
    import dtc_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    input  logic       blocked,
    output dt_cmd_e    cmd_kind
);

    always_comb begin
        cmd_kind = CMD_NONE;
        if (cmd_valid && !blocked) begin
            cmd_kind = decode_cmd(cmd_byte);
        end
    end

endmodule

// File: rtl/dtc_pulse_meter.sv
module dtc_pulse_meter
    import dtc_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int DIV_SHIFT = 4,
    parameter int DT_W      = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cs_n,
    input  dt_cmd_e         cmd_kind,
    output logic            measuring,
    output logic            upd_valid,
    output logic [DT_W-1:0] upd_value
);

    localparam int QUO_W = CNT_W - DIV_SHIFT;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    dt_state_e        state_q;
    logic             cs_q;
    logic [CNT_W-1:0] cnt_q;
    logic [QUO_W-1:0] quo;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DT_IDLE;
            cs_q    <= 1'b1;
            cnt_q   <= '0;
        end else begin
            cs_q <= cs_n;
            unique case (state_q)
                DT_IDLE: begin
                    if (cmd_kind == CMD_CAL) begin
                        state_q <= DT_ARMED;
                    end
                end
                DT_ARMED: begin
                    if (cmd_kind == CMD_ZERO) begin
                        state_q <= DT_IDLE;
                    end else if (cs_q && !cs_n) begin
                        state_q <= DT_MEASURE;
                        cnt_q   <= CNT_W'(1);
                    end
                end
                DT_MEASURE: begin
                    if (cs_n) begin
                        state_q <= DT_IDLE;
                    end else if (cnt_q != CNT_MAX) begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: state_q <= DT_IDLE;
            endcase
        end
    end

    assign measuring = (state_q == DT_MEASURE);
    assign upd_valid = measuring && cs_n;
    assign quo       = cnt_q[CNT_W-1:DIV_SHIFT];

    generate
        if (QUO_W > DT_W) begin : g_sat
            always_comb begin
                if (quo > QUO_W'({DT_W{1'b1}})) begin
                    upd_value = {DT_W{1'b1}};
                end else begin
                    upd_value = quo[DT_W-1:0];
                end
            end
        end else begin : g_direct
            assign upd_value = DT_W'(quo);
        end
    endgenerate

endmodule

// File: rtl/dtc_frame_mon.sv
module dtc_frame_mon #(
    parameter int N_LINES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               measuring,
    input  logic [N_LINES-1:0] lines,
    input  logic               err_clr,
    output logic               frame_err
);

    logic [N_LINES-1:0] lines_q;
    logic [N_LINES-1:0] toggled;

    genvar gi;
    generate
        for (gi = 0; gi < N_LINES; gi++) begin : g_line
            always_ff @(posedge clk) begin
                if (rst) begin
                    lines_q[gi] <= 1'b0;
                end else begin
                    lines_q[gi] <= lines[gi];
                end
            end
            assign toggled[gi] = lines[gi] ^ lines_q[gi];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_err <= 1'b0;
        end else if (measuring && (|toggled)) begin
            frame_err <= 1'b1;
        end else if (err_clr) begin
            frame_err <= 1'b0;
        end
    end

endmodule

// File: rtl/dt_cal_timer.sv
module dt_cal_timer
    import dtc_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int DIV_SHIFT = 4,
    parameter int DT_W      = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cs_n,
    input  logic            sdi,
    input  logic            sck,
    input  logic            cmd_valid,
    input  logic [7:0]      cmd_byte,
    input  logic            err_clr,
    output logic [DT_W-1:0] deadtime,
    output logic            frame_err,
    output logic            spi_ignore
);

    localparam logic [DT_W-1:0] DT_RESET = {DT_W{1'b1}};

    dt_cmd_e         cmd_kind;
    logic            measuring;
    logic            upd_valid;
    logic [DT_W-1:0] upd_value;

    dtc_cmd_decode u_decode (
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte),
        .blocked   (measuring),
        .cmd_kind  (cmd_kind)
    );

    dtc_pulse_meter #(
        .CNT_W     (CNT_W),
        .DIV_SHIFT (DIV_SHIFT),
        .DT_W      (DT_W)
    ) u_meter (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .cmd_kind  (cmd_kind),
        .measuring (measuring),
        .upd_valid (upd_valid),
        .upd_value (upd_value)
    );

    dtc_frame_mon #(
        .N_LINES (2)
    ) u_frame (
        .clk       (clk),
        .rst       (rst),
        .measuring (measuring),
        .lines     ({sck, sdi}),
        .err_clr   (err_clr),
        .frame_err (frame_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            deadtime <= DT_RESET;
        end else if (cmd_kind == CMD_ZERO) begin
            deadtime <= '0;
        end else if (upd_valid) begin
            deadtime <= upd_value;
        end
    end

    assign spi_ignore = measuring;

endmodule

// File: rtl/dtc_checker.sv
module dtc_checker (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       cmd_valid,
    input logic [7:0] cmd_byte,
    input logic       err_clr,
    input logic [7:0] deadtime,
    input logic       frame_err,
    input logic       spi_ignore
);

    assert_reset_value_R1: assert property (@(posedge clk)
        rst |=> (deadtime == 8'hFF && !frame_err && !spi_ignore));

    assert_zero_cmd_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_byte[7:5] == 3'b100 && !cmd_byte[0] && !spi_ignore)
        |=> (deadtime == 8'd0));

    assert_hold_outside_events_R5: assert property (@(posedge clk) disable iff (rst)
        (!spi_ignore && !(cmd_valid && cmd_byte[7:5] == 3'b100 && !cmd_byte[0]))
        |=> $stable(deadtime));

    assert_ignore_cmds_R7: assert property (@(posedge clk) disable iff (rst)
        (spi_ignore && !cs_n) |=> $stable(deadtime));

    assert_err_only_in_window_R10: assert property (@(posedge clk) disable iff (rst)
        (!spi_ignore && !frame_err) |=> !frame_err);

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (frame_err && !err_clr) |=> frame_err);

endmodule

bind dt_cal_timer dtc_checker chk_i (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .cmd_valid  (cmd_valid),
    .cmd_byte   (cmd_byte),
    .err_clr    (err_clr),
    .deadtime   (deadtime),
    .frame_err  (frame_err),
    .spi_ignore (spi_ignore)
);

// File: tb/dt_cal_timer_tb_top.sv
module dt_cal_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       sdi = 1'b0;
    logic       sck = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       err_clr = 1'b0;
    logic [7:0] deadtime;
    logic       frame_err;
    logic       spi_ignore;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    dt_cal_timer dut_i (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .sdi        (sdi),
        .sck        (sck),
        .cmd_valid  (cmd_valid),
        .cmd_byte   (cmd_byte),
        .err_clr    (err_clr),
        .deadtime   (deadtime),
        .frame_err  (frame_err),
        .spi_ignore (spi_ignore)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b);
        cmd_valid = 1'b1;
        cmd_byte  = b;
        tick(1);
        cmd_valid = 1'b0;
    endtask

    function automatic int expect_dt(input int n);
        int q;
        q = (n > 65535 ? 65535 : n) / 16;
        return (q > 255) ? 255 : q;
    endfunction

    // Low pulse of n sampled cycles; optional toggle of sdi in the middle.
    task automatic pulse(input int n, input bit tog);
        cs_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (tog && i == n / 2) sdi = ~sdi;
            tick(1);
        end
        cs_n = 1'b1;
        tick(1);
    endtask

    initial begin
        int prev;
        tick(3);
        // R1 reset state
        check(deadtime == 8'd255, "R1 deadtime", deadtime, 255);
        check(frame_err == 1'b0, "R1 frame_err", frame_err, 0);
        check(spi_ignore == 1'b0, "R1 spi_ignore", spi_ignore, 0);
        rst = 1'b0;
        tick(2);
        check(deadtime == 8'd255, "R1 after release", deadtime, 255);

        // R2/R5 sweep over pulse lengths with varied don't-care bits
        for (int n = 1; n <= 260; n++) begin
            logic [7:0] b;
            b = 8'h81 | 8'((n % 16) << 1);
            send(b);
            tick(1);
            pulse(n, 1'b0);
            check(deadtime == 8'(expect_dt(n)), "R2 R5 sweep", deadtime, expect_dt(n));
        end

        // R5 named corner cases
        send(8'h81); tick(1); pulse(480, 1'b0);
        check(deadtime == 8'd30, "R5 480 cycles", deadtime, 30);
        send(8'h9F); tick(1); pulse(4079, 1'b0);
        check(deadtime == 8'd254, "R5 4079 cycles", deadtime, 254);
        send(8'h81); tick(1); pulse(4080, 1'b0);
        check(deadtime == 8'd255, "R5 4080 cycles", deadtime, 255);

        // R3 zero command
        send(8'h80);
        check(deadtime == 8'd0, "R3 zero cmd", deadtime, 0);
        send(8'h81); tick(1); pulse(160, 1'b0);
        check(deadtime == 8'd10, "R5 after zero", deadtime, 10);

        // R6 counter saturation
        send(8'h81); tick(1); pulse(65636, 1'b0);
        check(deadtime == 8'd255, "R6 no wrap", deadtime, 255);

        // R3 zero cancels arming
        send(8'h81);
        send(8'h8E);
        check(deadtime == 8'd0, "R3 zero while armed", deadtime, 0);
        tick(1); pulse(320, 1'b0);
        check(deadtime == 8'd0, "R3 arming cancelled", deadtime, 0);

        // R2 wrong opcodes neither arm nor clear
        send(8'h81); tick(1); pulse(96, 1'b0);
        check(deadtime == 8'd6, "R2 setup", deadtime, 6);
        send(8'hA1); send(8'h01); send(8'hE0); send(8'h00);
        tick(1);
        check(deadtime == 8'd6, "R2 foreign opcodes no clear", deadtime, 6);
        pulse(480, 1'b0);
        check(deadtime == 8'd6, "R2 foreign opcodes no arm", deadtime, 6);

        // R8 arming consumed
        send(8'h81); tick(1); pulse(64, 1'b0);
        check(deadtime == 8'd4, "R8 first pulse", deadtime, 4);
        tick(2); pulse(800, 1'b0);
        check(deadtime == 8'd4, "R8 second pulse ignored", deadtime, 4);

        // R4 arm while cs_n already low
        cs_n = 1'b0;
        send(8'h81);
        tick(40);
        cs_n = 1'b1;
        tick(2);
        check(deadtime == 8'd4, "R4 no measure without falling edge", deadtime, 4);
        pulse(208, 1'b0);
        check(deadtime == 8'd13, "R4 measured after fresh fall", deadtime, 13);

        // R7 ignore window and commands inside it
        send(8'h81); tick(1);
        cs_n = 1'b0;
        tick(1);
        check(spi_ignore == 1'b1, "R7 ignore high", spi_ignore, 1);
        tick(10);
        send(8'h80);
        send(8'h81);
        tick(1);
        check(deadtime == 8'd13, "R7 zero ignored in window", deadtime, 13);
        tick(240 - 14);
        cs_n = 1'b1;
        tick(1);
        check(deadtime == 8'd15, "R7 pulse kept", deadtime, 15);
        check(spi_ignore == 1'b0, "R7 ignore low after", spi_ignore, 0);
        pulse(480, 1'b0);
        check(deadtime == 8'd15, "R7 no re-arm from ignored cmd", deadtime, 15);

        // R10 toggles outside window do not set error
        sdi = 1'b1; tick(1); sck = 1'b1; tick(1); sdi = 1'b0; sck = 1'b0; tick(2);
        check(frame_err == 1'b0, "R10 no error outside window", frame_err, 0);

        // R9 toggle inside window, pulse still used
        send(8'h81); tick(1); pulse(112, 1'b1);
        check(frame_err == 1'b1, "R9 sdi toggle flags error", frame_err, 1);
        check(deadtime == 8'd7, "R9 pulse still used", deadtime, 7);
        tick(20);
        check(frame_err == 1'b1, "R10 error sticky", frame_err, 1);
        err_clr = 1'b1; tick(1); err_clr = 1'b0;
        check(frame_err == 1'b0, "R10 clear strobe", frame_err, 0);

        // R9 sck toggle
        send(8'h81); tick(1);
        cs_n = 1'b0; tick(5); sck = 1'b1; tick(5); sck = 1'b0; tick(22);
        cs_n = 1'b1; tick(1);
        check(frame_err == 1'b1, "R9 sck toggle flags error", frame_err, 1);
        check(deadtime == 8'd2, "R9 sck pulse used", deadtime, 2);
        err_clr = 1'b1; tick(1); err_clr = 1'b0;
        prev = deadtime;
        check(frame_err == 1'b0 && prev == 2, "R10 cleared again", frame_err, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule